// File: doc/BRIEF.md
# Tile 2x2 Smoothing Array

This block smooths a square tile of 8-bit greyscale pixels (10 by 10 with the default parameters). Every output pixel is the rounded mean of a 2x2 window whose top-left corner is that pixel. One identical averaging cell per pixel works on the whole tile at once, so a tile is finished on a fixed schedule whatever its contents.

The whole tile arrives on one wide parallel bus and is captured by a single-cycle `start` pulse. The smoothed tile leaves on an equally wide bus, and a one-cycle `done` strobe marks it. Windows on the last column borrow the column to their left. Windows on the last row borrow the row above. No pixel from outside the tile is ever needed, so a controller elsewhere can walk tiles across a frame in any order.

Top module: `tile_smooth`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0 and every bit of `resultOut` is 0.
- R2: A `start` sampled high while idle captures `tileIn`. `done` is high for exactly one cycle, in the cycle following the sixth rising edge after the capturing edge.
- R3: For a pixel at row r < 9 and column c < 9, the output byte is (p(r,c) + p(r,c+1) + p(r+1,c) + p(r+1,c+1) + 2) >> 2. This is the rounded mean of four pixels, with halves rounded up.
- R4: For a pixel in column 9 and row r < 9, the horizontal partner is column 8: the output is the mean of p(r,9), p(r,8), p(r+1,9) and p(r+1,8), rounded as in R3.
- R5: For a pixel in row 9 and column c < 9, the vertical partner is row 8: the output is the mean of p(9,c), p(9,c+1), p(8,c) and p(8,c+1), rounded as in R3.
- R6: The corner pixel (9,9) averages p(9,9), p(9,8), p(8,9) and p(8,8), rounded as in R3.
- R7: A `start` sampled while a tile is in flight (from the capturing edge up to and including the edge that raises `done`) is ignored. It causes no extra `done`, and the results belong to the tile that was captured.
- R8: `resultOut` changes only at the edge that raises `done`, and it holds its value between `done` pulses.
- R9: On both buses, pixel (r,c) occupies bits [(r*10+c)*8+7 : (r*10+c)*8], so pixel (0,0) is the least significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture `tileIn` and begin a tile when idle |
| tileIn | input | 800 | Input tile, 100 pixels of 8 bits |
| done | output | 1 | One-cycle strobe: `resultOut` holds a new tile |
| resultOut | output | 800 | Smoothed tile, same layout as `tileIn` |

## Verification
A stage strobe that fires in the wrong cycle moves `done` away from its fixed place, and the bench sees this on the first tile. It also lets stale sums or stale windows reach `resultOut`, which shows as byte mismatches at that same `done`. A wrong tap choice in one cell changes only that cell's byte, and only for tiles that are not flat. The gradient and random tiles therefore expose it on the first such tile, and the failing byte's position names the edge rule concerned. A phase counter that lets a busy `start` through shows up as an early or extra `done` within seven cycles of the second `start`.

// File: rtl/tile_avg_pkg.sv
package tile_avg_pkg;

  // Stage strobes issued by the sequencer to the datapath.
  typedef struct packed {
    logic capture;   // latch the input tile
    logic pack;      // build every cell's four-tap word
    logic sum;       // register the rounded sums
    logic avg;       // register the averages
    logic publish;   // move averages to the output bus
  } stage_strobes_t;

endpackage

// File: rtl/tile_avg_ctrl.sv
module tile_avg_ctrl
  import tile_avg_pkg::*;
#(
  parameter int LATENCY = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output stage_strobes_t strobes,
  output logic           done
);

  localparam int PW = $clog2(LATENCY + 2);

  logic [PW-1:0] phase;
  logic          busy;

  assign busy = (phase != '0);

  always_comb begin
    strobes.capture = start && !busy;
    strobes.pack    = (phase == PW'(1));
    strobes.sum     = (phase == PW'(2));
    strobes.avg     = (phase == PW'(3));
    strobes.publish = (phase == PW'(LATENCY));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobes.publish;
      if (strobes.capture)      phase <= PW'(1);
      else if (strobes.publish) phase <= '0;
      else if (busy)            phase <= phase + PW'(1);
    end
  end

  // Checker state: edges elapsed since the last accepted start.
  logic [PW:0] sinceStart;
  always_ff @(posedge clk) begin
    if (rst)                                          sinceStart <= '0;
    else if (strobes.capture)                         sinceStart <= (PW+1)'(1);
    else if (sinceStart != '0 && sinceStart <= (PW+1)'(LATENCY)) sinceStart <= sinceStart + (PW+1)'(1);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_DONE_AT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> sinceStart == (PW+1)'(LATENCY + 1)); // R2

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    busy && !strobes.publish |=> phase == $past(phase) + PW'(1)); // R7

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.capture, strobes.pack, strobes.sum, strobes.avg, strobes.publish})); // R2

endmodule

// File: rtl/tile_avg_cell.sv
module tile_avg_cell
  import tile_avg_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  stage_strobes_t     strobes,
  input  logic [4*PIX_W-1:0] taps,
  output logic [PIX_W-1:0]   avgOut
);

  localparam int SUMW = PIX_W + 2;

  logic [PIX_W-1:0] tapSelf, tapHoriz, tapVert, tapDiag;
  logic [SUMW-1:0]  sumReg;

  assign {tapSelf, tapHoriz, tapVert, tapDiag} = taps;

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
      avgOut <= '0;
    end else begin
      if (strobes.sum)
        sumReg <= SUMW'(tapSelf) + SUMW'(tapHoriz) + SUMW'(tapVert)
                + SUMW'(tapDiag) + SUMW'(2);
      if (strobes.avg)
        avgOut <= sumReg[SUMW-1:2];
    end
  end

  // Checker: a mean never leaves the range spanned by its taps.
  logic [PIX_W-1:0] tapLo, tapHi;
  always_comb begin
    tapLo = tapSelf;
    tapHi = tapSelf;
    if (tapHoriz < tapLo) tapLo = tapHoriz;
    if (tapVert  < tapLo) tapLo = tapVert;
    if (tapDiag  < tapLo) tapLo = tapDiag;
    if (tapHoriz > tapHi) tapHi = tapHoriz;
    if (tapVert  > tapHi) tapHi = tapVert;
    if (tapDiag  > tapHi) tapHi = tapDiag;
  end

  AST_MEAN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.avg) && !$past(strobes.pack, 2) |-> avgOut >= tapLo && avgOut <= tapHi); // R3

endmodule

// File: rtl/tile_avg_datapath.sv
module tile_avg_datapath
  import tile_avg_pkg::*;
#(
  parameter int TILE_W = 10,
  parameter int TILE_H = 10,
  parameter int PIX_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  stage_strobes_t                  strobes,
  input  logic [TILE_W*TILE_H*PIX_W-1:0]  tileIn,
  output logic [TILE_W*TILE_H*PIX_W-1:0]  resultOut
);

  localparam int NPIX   = TILE_W * TILE_H;
  localparam int TAPW   = 4 * PIX_W;
  localparam int TILEB  = NPIX * PIX_W;
  localparam int WINB   = NPIX * TAPW;

  logic [TILEB-1:0] tileReg;
  logic [WINB-1:0]  windowNext;
  logic [WINB-1:0]  windowBus;
  logic [TILEB-1:0] avgAll;

  always_ff @(posedge clk) begin
    if (rst) begin
      tileReg   <= '0;
      windowBus <= '0;
      resultOut <= '0;
    end else begin
      if (strobes.capture) tileReg   <= tileIn;
      if (strobes.pack)    windowBus <= windowNext;
      if (strobes.publish) resultOut <= avgAll;
    end
  end

  for (genvar r = 0; r < TILE_H; r++) begin : gRow
    for (genvar c = 0; c < TILE_W; c++) begin : gCol
      // Edge windows fold back inward instead of leaving the tile.
      localparam int HC  = (c == TILE_W - 1) ? c - 1 : c + 1;
      localparam int VR  = (r == TILE_H - 1) ? r - 1 : r + 1;
      localparam int IDX = r * TILE_W + c;

      assign windowNext[IDX*TAPW +: TAPW] = {
        tileReg[(r  * TILE_W + c ) * PIX_W +: PIX_W],
        tileReg[(r  * TILE_W + HC) * PIX_W +: PIX_W],
        tileReg[(VR * TILE_W + c ) * PIX_W +: PIX_W],
        tileReg[(VR * TILE_W + HC) * PIX_W +: PIX_W]
      };

      tile_avg_cell #(.PIX_W(PIX_W)) uCell (
        .clk     (clk),
        .rst     (rst),
        .strobes (strobes),
        .taps    (windowBus[IDX*TAPW +: TAPW]),
        .avgOut  (avgAll[IDX*PIX_W +: PIX_W])
      );
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobes.publish |=> $stable(resultOut)); // R8

  AST_TILE_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable(tileReg)); // R7

endmodule

// File: rtl/tile_smooth.sv
module tile_smooth
  import tile_avg_pkg::*;
#(
  parameter int TILE_W  = 10,
  parameter int TILE_H  = 10,
  parameter int PIX_W   = 8,
  parameter int LATENCY = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [TILE_W*TILE_H*PIX_W-1:0] tileIn,
  output logic                           done,
  output logic [TILE_W*TILE_H*PIX_W-1:0] resultOut
);

  stage_strobes_t strobes;

  tile_avg_ctrl #(.LATENCY(LATENCY)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  tile_avg_datapath #(
    .TILE_W (TILE_W),
    .TILE_H (TILE_H),
    .PIX_W  (PIX_W)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .tileIn    (tileIn),
    .resultOut (resultOut)
  );

endmodule

// File: tb/tb_tile_smooth.sv
`timescale 1ns/1ps
module tb_tile_smooth;

  localparam int W = 10;
  localparam int H = 10;
  localparam int NB = W * H * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NB-1:0] tileIn = '0;
  logic          done;
  logic [NB-1:0] resultOut;

  int compared = 0;
  int mismatched = 0;
  bit checking = 1'b0;

  always #5 clk = ~clk;

  tile_smooth dut (
    .clk(clk), .rst(rst), .start(start), .tileIn(tileIn),
    .done(done), .resultOut(resultOut)
  );

  // Behavioural expectation of one smoothed tile (R3..R6, layout R9).
  function automatic logic [NB-1:0] smoothRef(input logic [NB-1:0] t);
    logic [NB-1:0] o;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        int hc, vr, s;
        hc = (c == W - 1) ? W - 2 : c + 1;
        vr = (r == H - 1) ? H - 2 : r + 1;
        s = int'(t[(r*W+c)*8 +: 8]) + int'(t[(r*W+hc)*8 +: 8])
          + int'(t[(vr*W+c)*8 +: 8]) + int'(t[(vr*W+hc)*8 +: 8]) + 2;
        o[(r*W+c)*8 +: 8] = 8'(s / 4);
      end
    end
    return o;
  endfunction

  // Reference model, advanced on the same edges as the design.
  int            inFlight = 0;
  logic [NB-1:0] pendRes = '0;
  logic          expDone = 1'b0;
  logic [NB-1:0] expRes = '0;

  always @(posedge clk) begin
    if (rst) begin
      inFlight = 0;
      expDone  = 1'b0;
      expRes   = '0;
    end else begin
      expDone = 1'b0;
      if (inFlight == 0) begin
        if (start) begin
          inFlight = 1;
          pendRes  = smoothRef(tileIn);
        end
      end else begin
        inFlight++;
        if (inFlight == 7) begin
          expDone  = 1'b1;
          expRes   = pendRes;
          inFlight = 0;
        end
      end
    end
  end

  // Compare on every clock, just after the edge.
  always @(posedge clk) begin
    #1;
    if (checking) begin
      compared++;
      if (done !== expDone) begin
        mismatched++;
        $display("FAIL R2/R7 done: actual %0b expected %0b at %0t", done, expDone, $time);
      end
      if (expDone) begin
        for (int r = 0; r < H; r++) begin
          for (int c = 0; c < W; c++) begin
            logic [7:0] a, e;
            a = resultOut[(r*W+c)*8 +: 8];
            e = expRes[(r*W+c)*8 +: 8];
            compared++;
            if (a !== e) begin
              mismatched++;
              if (r == H-1 && c == W-1)
                $display("FAIL R6 pixel(%0d,%0d): actual %0d expected %0d", r, c, a, e);
              else if (c == W-1)
                $display("FAIL R4 pixel(%0d,%0d): actual %0d expected %0d", r, c, a, e);
              else if (r == H-1)
                $display("FAIL R5 pixel(%0d,%0d): actual %0d expected %0d", r, c, a, e);
              else
                $display("FAIL R3 R9 pixel(%0d,%0d): actual %0d expected %0d", r, c, a, e);
            end
          end
        end
      end else begin
        compared++;
        if (resultOut !== expRes) begin
          mismatched++;
          $display("FAIL R8 held result: actual %h expected %h", resultOut, expRes);
        end
      end
    end
  end

  task automatic pulseStart(input logic [NB-1:0] t);
    @(negedge clk);
    start  = 1'b1;
    tileIn = t;
    @(negedge clk);
    start  = 1'b0;
  endtask

  function automatic logic [NB-1:0] randTile();
    logic [NB-1:0] t;
    for (int k = 0; k < W*H; k++) t[k*8 +: 8] = 8'($urandom_range(0, 255));
    return t;
  endfunction

  task automatic runTile(input logic [NB-1:0] t);
    pulseStart(t);
    repeat (8) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin : stimulus
    logic [NB-1:0] t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compared++;
    if (done !== 1'b0 || resultOut !== '0) begin
      mismatched++;
      $display("FAIL R1 reset state: actual done=%0b result=%h expected 0", done, resultOut);
    end
    checking = 1'b1;

    // Flat tiles: all zero and all 255 (rounding must not overflow).
    runTile('0);
    runTile({NB{1'b1}});

    // Gradient tiles: make every fold-back edge visible (R4, R5, R6).
    for (int k = 0; k < W*H; k++) t[k*8 +: 8] = 8'(((k / W) * 23 + (k % W) * 7) % 256);
    runTile(t);
    for (int k = 0; k < W*H; k++) t[k*8 +: 8] = 8'(255 - (k % W) * 25);
    runTile(t);
    for (int k = 0; k < W*H; k++) t[k*8 +: 8] = 8'((k / W) * 28 + ((k % 2) * 3));
    runTile(t);

    // Random tiles (R3, R9).
    for (int n = 0; n < 20; n++) runTile(randTile());

    // Starts while busy are ignored (R7).
    pulseStart(randTile());
    @(negedge clk);
    start = 1'b1; tileIn = randTile();
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; tileIn = randTile();
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);

    // Start held high with a changing tile: back-to-back acceptance (R2, R7).
    for (int n = 0; n < 30; n++) begin
      start = 1'b1;
      tileIn = randTile();
      @(negedge clk);
    end
    start = 1'b0;
    repeat (10) @(negedge clk);

    // Long idle: result must stay held (R8).
    repeat (20) @(negedge clk);

    finishRun();
  end

endmodule